// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This unit turns a logical address, given as a segment number plus an offset, into a physical address. It gates the translation through a fixed sequence of protection checks. A configuration pair gives the position and size of a descriptor table in memory. For each request the unit:

- checks the segment number against the table size,
- fetches the segment's descriptor through a single-cycle-latency read port,
- checks the descriptor's valid flag, the segment limit and the access permission,
- then either reports the physical address or a single fault code.

A one-entry descriptor cache, tagged by segment number, lets a run of requests to the same segment skip the memory read. Any change of either table configuration input empties the cache. Requests are taken only while the unit is idle. Each request ends in a one-cycle completion pulse.

Top module: `seg_xlate`

## Requirements
- R1: After reset, done, fault, pa and mem_rd_en are all 0.
- R2: A request whose segment number is greater than or equal to tbl_len completes with fault code 1 one cycle after it is accepted, with no memory read.
- R3: On a cache miss the unit issues exactly one read, with mem_rd_en high for one cycle and mem_rd_addr = tbl_base + segment number. Data is expected on mem_rd_data the cycle after. Descriptor layout: bits [PA_W-1:0] base, bits [PA_W+OFF_W-1:PA_W] limit, then valid, read, write and execute flags in the four bits above.
- R4: A descriptor whose valid flag is 0 gives fault code 2.
- R5: An offset greater than or equal to the limit gives fault code 3. An offset of limit-1 is legal.
- R6: Access codes are 0 read, 1 write and 2 execute. Each needs its own flag set, or fault code 4 results. Code 3 is always denied.
- R7: When several faults apply, only the first in the order length (1), valid (2), limit (3), permission (4) is reported.
- R8: A legal access reports fault code 0 and pa = base + offset, modulo 2^PA_W.
- R9: done is a one-cycle pulse. It rises three cycles after acceptance on a miss, two on a cache hit and one on a length fault.
- R10: A request to the segment of the last fetched descriptor uses the cached copy and performs no memory read, even if memory has changed since.
- R11: Any change of tbl_base or tbl_len empties the cache, so the next request reads memory again at the new address.
- R12: A request raised while a translation is in progress is ignored and yields no extra completion and no extra read.
- R13: Whenever fault is nonzero at completion, pa is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base | input | TBL_AW | Memory address of descriptor 0 |
| tbl_len | input | SEG_W+1 | Number of descriptors in the table |
| req | input | 1 | Request strobe, sampled while idle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset inside the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| mem_rd_en | output | 1 | Descriptor read enable |
| mem_rd_addr | output | TBL_AW | Descriptor read address |
| mem_rd_data | input | DESC_W | Descriptor returned the cycle after the read |
| done | output | 1 | Completion pulse |
| pa | output | PA_W | Physical address, valid with done |
| fault | output | 3 | Fault code, valid with done |

## Verification
Legal reads, writes and executes are driven across several segments, including one whose base plus offset wraps past the top of the physical space. This separates correct addition and truncation from a plain pass-through. Crafted descriptors place each fault alone and then in combinations, which shows whether the priority order is kept. Repeated, changed and reconfigured segment numbers distinguish hits from misses by latency and read count. A memory word altered behind a cached segment proves that the cached copy is used. A request pulsed mid-translation shows that busy requests are dropped.

// File: rtl/seg_pkg.sv
// Shared types for the segment translation unit.
// Assumes fault codes fit in three bits and access codes in two.
package seg_pkg;
    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_LEN     = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PERM    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_RD   = 2'd0,
        ACC_WR   = 2'd1,
        ACC_EX   = 2'd2,
        ACC_RSVD = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HIT   = 2'd1,
        S_FETCH = 2'd2,
        S_WAIT  = 2'd3
    } xl_state_e;
endpackage

// File: rtl/seg_cfg_watch.sv
// Watches the table configuration inputs and flags any change.
// Assumes a change is visible for one cycle after the inputs move.
module seg_cfg_watch #(
    parameter int TBL_AW = 10,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_AW-1:0] tbl_base,
    input  logic [LEN_W-1:0]  tbl_len,
    output logic              chg
);
    logic [TBL_AW-1:0] base_q;
    logic [LEN_W-1:0]  len_q;

    // Keep the last seen configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else begin
            base_q <= tbl_base;
            len_q  <= tbl_len;
        end
    end

    // A difference from the stored copy means a write happened.
    always_comb chg = (base_q != tbl_base) || (len_q != tbl_len);
endmodule

// File: rtl/seg_desc_cache.sv
// One-entry descriptor store tagged by segment number.
// Assumes invalidation outranks a fill in the same cycle.
// USE_CACHE = 0 builds a store that never hits.
module seg_desc_cache #(
    parameter bit USE_CACHE = 1'b1,
    parameter int SEG_W     = 6,
    parameter int DESC_W    = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic              fill,
    input  logic [SEG_W-1:0]  fill_tag,
    input  logic [DESC_W-1:0] fill_data,
    input  logic [SEG_W-1:0]  look_tag,
    output logic              hit,
    output logic [DESC_W-1:0] data
);
    generate
        if (USE_CACHE) begin : g_cache
            logic              vld_q;
            logic [SEG_W-1:0]  tag_q;
            logic [DESC_W-1:0] dat_q;

            // Hold the most recently fetched descriptor.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    tag_q <= '0;
                    dat_q <= '0;
                end else if (inv) begin
                    vld_q <= 1'b0;
                end else if (fill) begin
                    vld_q <= 1'b1;
                    tag_q <= fill_tag;
                    dat_q <= fill_data;
                end
            end

            // Tag compare.
            always_comb begin
                hit  = vld_q && (tag_q == look_tag);
                data = dat_q;
            end

            // R11: an invalidation leaves the entry empty.
            p_inv_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
                inv |=> !vld_q);
        end else begin : g_nocache
            // No storage: every lookup misses.
            always_comb begin
                hit  = 1'b0;
                data = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/seg_check.sv
// Combinational descriptor checks and address sum.
// Order: valid flag, limit, permission. The length check lives in the top.
// Assumes the descriptor layout {ex, wr, rd, valid, limit, base}.
module seg_check
    import seg_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PA_W  = 20
) (
    input  logic [PA_W+OFF_W+3:0] desc,
    input  logic [OFF_W-1:0]      off,
    input  logic [1:0]            acc,
    output fault_e                code,
    output logic [PA_W-1:0]       pa
);
    localparam int LIM_LO = PA_W;
    localparam int VLD_B  = PA_W + OFF_W;

    logic [PA_W-1:0]  d_base;
    logic [OFF_W-1:0] d_limit;
    logic             d_vld;
    logic [2:0]       d_perm;
    logic             perm_ok;

    // Field extraction.
    always_comb begin
        d_base  = desc[PA_W-1:0];
        d_limit = desc[LIM_LO +: OFF_W];
        d_vld   = desc[VLD_B];
        d_perm  = desc[VLD_B+1 +: 3];
    end

    // Pick the permission flag for the access type; the reserved code is denied.
    always_comb begin
        case (acc_e'(acc))
            ACC_RD:  perm_ok = d_perm[0];
            ACC_WR:  perm_ok = d_perm[1];
            ACC_EX:  perm_ok = d_perm[2];
            default: perm_ok = 1'b0;
        endcase
    end

    // Prioritised fault selection and address sum.
    always_comb begin
        pa = '0;
        if (!d_vld)                code = FLT_INVALID;
        else if (off >= d_limit)   code = FLT_LIMIT;
        else if (!perm_ok)         code = FLT_PERM;
        else begin
            code = FLT_NONE;
            pa   = d_base + PA_W'(off);
        end
    end

    // R5: no legal verdict for an offset at or past the limit.
    always_comb begin
        if (code == FLT_NONE) begin
            p_legal_in_limit_r5: assert (off < desc[LIM_LO +: OFF_W]);
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Segment translation unit top.
// Accepts a request when idle, checks it against the table length, then
// obtains the descriptor from the one-entry cache or through one read with
// one-cycle latency. It registers pa and fault with a one-cycle done pulse.
// Assumes mem_rd_data is valid the cycle after mem_rd_en.
module seg_xlate
    import seg_pkg::*;
#(
    parameter int SEG_W     = 6,
    parameter int OFF_W     = 12,
    parameter int PA_W      = 20,
    parameter int TBL_AW    = 10,
    parameter bit USE_CACHE = 1'b1,
    localparam int LEN_W    = SEG_W + 1,
    localparam int DESC_W   = PA_W + OFF_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_AW-1:0] tbl_base,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic              req,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_rd_en,
    output logic [TBL_AW-1:0] mem_rd_addr,
    input  logic [DESC_W-1:0] mem_rd_data,
    output logic              done,
    output logic [PA_W-1:0]   pa,
    output logic [2:0]        fault
);
    xl_state_e         state;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        acc_q;
    logic              done_q;
    logic [PA_W-1:0]   pa_q;
    fault_e            fault_q;

    logic              cfg_chg;
    logic              c_hit;
    logic [DESC_W-1:0] c_data;
    logic              hit_now;
    logic              len_bad;
    logic [DESC_W-1:0] chk_desc;
    fault_e            chk_code;
    logic [PA_W-1:0]   chk_pa;

    seg_cfg_watch #(.TBL_AW(TBL_AW), .LEN_W(LEN_W)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tbl_base (tbl_base),
        .tbl_len  (tbl_len),
        .chg      (cfg_chg)
    );

    seg_desc_cache #(.USE_CACHE(USE_CACHE), .SEG_W(SEG_W), .DESC_W(DESC_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv       (cfg_chg),
        .fill      (state == S_WAIT),
        .fill_tag  (seg_q),
        .fill_data (mem_rd_data),
        .look_tag  (req_seg),
        .hit       (c_hit),
        .data      (c_data)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .desc (chk_desc),
        .off  (off_q),
        .acc  (acc_q),
        .code (chk_code),
        .pa   (chk_pa)
    );

    // Length check and cache decision for an incoming request.
    always_comb begin
        len_bad = ({1'b0, req_seg} >= tbl_len);
        hit_now = c_hit && !cfg_chg;
    end

    // Descriptor source: the memory port while waiting, the cache otherwise.
    always_comb chk_desc = (state == S_WAIT) ? mem_rd_data : c_data;

    // Read port drive during the fetch cycle.
    always_comb begin
        mem_rd_en   = (state == S_FETCH);
        mem_rd_addr = (state == S_FETCH) ? (tbl_base + TBL_AW'(seg_q)) : '0;
    end

    // Request sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            seg_q   <= '0;
            off_q   <= '0;
            acc_q   <= '0;
            done_q  <= 1'b0;
            pa_q    <= '0;
            fault_q <= FLT_NONE;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req) begin
                        seg_q <= req_seg;
                        off_q <= req_off;
                        acc_q <= req_acc;
                        if (len_bad) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_LEN;
                            pa_q    <= '0;
                        end else if (hit_now) begin
                            state <= S_HIT;
                        end else begin
                            state <= S_FETCH;
                        end
                    end
                end
                S_FETCH: state <= S_WAIT;
                default: begin
                    done_q  <= 1'b1;
                    fault_q <= chk_code;
                    pa_q    <= chk_pa;
                    state   <= S_IDLE;
                end
            endcase
        end
    end

    // Output drive.
    always_comb begin
        done  = done_q;
        pa    = pa_q;
        fault = fault_q;
    end

    // R2: an out-of-range segment completes next cycle with code 1 and no read.
    p_len_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req && len_bad) |=> (done && fault == 3'd1 && !mem_rd_en));

    // R3: a read lasts one cycle.
    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R9: completion follows a read after two cycles.
    p_miss_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 done);

    // R9: done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a hit issues no read.
    p_hit_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req && !len_bad && hit_now) |=> !mem_rd_en);

    // R13: a faulting completion carries a zero address.
    p_fault_pa_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (pa == '0));

    // R7: only defined codes appear.
    p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault <= 3'd4));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    localparam int SEG_W  = 6;
    localparam int OFF_W  = 12;
    localparam int PA_W   = 20;
    localparam int TBL_AW = 10;
    localparam int DESC_W = PA_W + OFF_W + 4;
    localparam int MEMN   = 1 << TBL_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TBL_AW-1:0] tbl_base = '0;
    logic [SEG_W:0]    tbl_len = '0;
    logic              req = 1'b0;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              mem_rd_en;
    logic [TBL_AW-1:0] mem_rd_addr;
    logic [DESC_W-1:0] mem_rd_data = '0;
    logic              done;
    logic [PA_W-1:0]   pa;
    logic [2:0]        fault;

    logic [DESC_W-1:0] mem [MEMN];
    int                n_reads = 0;
    logic [TBL_AW-1:0] last_addr = '0;
    int                n_checks = 0;
    int                n_fail = 0;
    bit                mc_vld = 1'b0;
    logic [SEG_W-1:0]  mc_seg = '0;
    logic [DESC_W-1:0] mc_desc = '0;

    always #4 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .req(req), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done(done), .pa(pa), .fault(fault)
    );

    // Descriptor memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr];
            last_addr   <= mem_rd_addr;
            n_reads     <= n_reads + 1;
        end
    end

    function automatic logic [DESC_W-1:0] mk(input logic [PA_W-1:0] b, input logic [OFF_W-1:0] l,
                                             input bit v, input bit r, input bit w, input bit x);
        return {x, w, r, v, l, b};
    endfunction

    function automatic logic [2:0] exp_code(input logic [DESC_W-1:0] d, input logic [OFF_W-1:0] o,
                                            input logic [1:0] a);
        logic [OFF_W-1:0] lim;
        bit ok;
        lim = d[PA_W +: OFF_W];
        ok  = (a == 2'd0) ? d[PA_W+OFF_W+1] : (a == 2'd1) ? d[PA_W+OFF_W+2] :
              (a == 2'd2) ? d[PA_W+OFF_W+3] : 1'b0;
        if (!d[PA_W+OFF_W]) return 3'd2;
        if (o >= lim)       return 3'd3;
        if (!ok)            return 3'd4;
        return 3'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [TBL_AW-1:0] b, input logic [SEG_W:0] l);
        @(negedge clk);
        if (b != tbl_base || l != tbl_len) mc_vld = 1'b0;
        tbl_base = b;
        tbl_len  = l;
    endtask

    // One request with full result checking against the model.
    task automatic do_req(input string tag, input logic [SEG_W-1:0] s,
                          input logic [OFF_W-1:0] o, input logic [1:0] a);
        int lat_e, rd_e, lat, r0;
        logic [2:0] f_e;
        logic [PA_W-1:0] pa_e;
        logic [DESC_W-1:0] d;
        logic [TBL_AW-1:0] ad_e;
        ad_e = tbl_base + TBL_AW'(s);
        pa_e = '0;
        if ({1'b0, s} >= tbl_len) begin
            f_e = 3'd1; lat_e = 1; rd_e = 0; d = '0;
        end else begin
            if (mc_vld && mc_seg == s) begin
                d = mc_desc; lat_e = 2; rd_e = 0;
            end else begin
                d = mem[ad_e]; lat_e = 3; rd_e = 1;
                mc_vld = 1'b1; mc_seg = s; mc_desc = d;
            end
            f_e = exp_code(d, o, a);
            if (f_e == 3'd0) pa_e = d[PA_W-1:0] + PA_W'(o);
        end
        @(negedge clk);
        r0 = n_reads;
        req = 1'b1; req_seg = s; req_off = o; req_acc = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1, tag, "done seen", done, 1);
        chk(lat == lat_e, (lat_e == 3) ? "R9 miss" : (lat_e == 2) ? "R10 hit" : "R2", "latency", lat, lat_e);
        chk(fault == f_e, tag, "fault", fault, f_e);
        chk(pa == pa_e, (f_e != 0) ? "R13" : "R8", "pa", pa, pa_e);
        chk(n_reads - r0 == rd_e, (rd_e == 0) ? "R10/R2 no read" : "R3", "reads", n_reads - r0, rd_e);
        if (rd_e == 1) chk(last_addr == ad_e, "R3", "read address", last_addr, ad_e);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done pulse width", done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(done == 0 && fault == 0 && pa == 0 && mem_rd_en == 0, "R1", "reset outputs",
            {done, fault, mem_rd_en}, 0);
    endtask

    task automatic t_translate();
        do_req("R8", 6'd2, 12'h010, 2'd0);
        do_req("R8", 6'd3, 12'h1FF, 2'd1);
        do_req("R8", 6'd5, 12'h1F0, 2'd0);
        chk(pa == 20'h000F0, "R8", "wrapped address", pa, 20'h000F0);
    endtask

    task automatic t_length();
        do_req("R2", 6'd16, 12'h0, 2'd0);
        do_req("R2", 6'd40, 12'h0, 2'd0);
        set_cfg(10'd100, 7'd0);
        do_req("R2", 6'd0, 12'h0, 2'd0);
        set_cfg(10'd100, 7'd16);
    endtask

    task automatic t_invalid();
        do_req("R4", 6'd6, 12'h001, 2'd0);
    endtask

    task automatic t_limit();
        do_req("R5", 6'd7, 12'h07F, 2'd0);
        do_req("R5", 6'd7, 12'h080, 2'd0);
        do_req("R5", 6'd7, 12'hFFF, 2'd0);
        do_req("R5", 6'd12, 12'h000, 2'd0);
    endtask

    task automatic t_perm();
        do_req("R6", 6'd8, 12'h004, 2'd0);
        do_req("R6", 6'd8, 12'h004, 2'd1);
        do_req("R6", 6'd8, 12'h004, 2'd2);
        do_req("R6", 6'd8, 12'h004, 2'd3);
        do_req("R6", 6'd9, 12'h004, 2'd2);
        do_req("R6", 6'd9, 12'h004, 2'd0);
    endtask

    task automatic t_priority();
        do_req("R7", 6'd10, 12'h020, 2'd1);
        do_req("R7", 6'd11, 12'h020, 2'd1);
        do_req("R7", 6'd11, 12'h005, 2'd1);
        do_req("R7", 6'd20, 12'hFFF, 2'd3);
    endtask

    task automatic t_cache();
        do_req("R10", 6'd2, 12'h008, 2'd0);
        do_req("R10", 6'd2, 12'h00C, 2'd0);
        mem[102] = mk(20'h55000, 12'h200, 1, 1, 1, 1);
        do_req("R10", 6'd2, 12'h00C, 2'd0);
        chk(pa == 20'h0200C, "R10", "stale cached base used", pa, 20'h0200C);
    endtask

    task automatic t_invalidate();
        set_cfg(10'd100, 7'd20);
        do_req("R11", 6'd2, 12'h00C, 2'd0);
        chk(pa == 20'h5500C, "R11", "refetched base", pa, 20'h5500C);
        set_cfg(10'd300, 7'd20);
        do_req("R11", 6'd2, 12'h00C, 2'd0);
        chk(pa == 20'h7700C, "R11", "new table base", pa, 20'h7700C);
    endtask

    task automatic t_busy();
        int dn, r0;
        dn = 0;
        @(negedge clk);
        r0 = n_reads;
        req = 1'b1; req_seg = 6'd3; req_off = 12'h001; req_acc = 2'd0;
        @(posedge clk);
        @(negedge clk);
        req_seg = 6'd4;
        if (done) dn++;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        if (done) dn++;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) dn++;
        end
        mc_vld = 1'b1; mc_seg = 6'd3; mc_desc = mem[300 + 3];
        chk(dn == 1, "R12", "completions", dn, 1);
        chk(n_reads - r0 == 1, "R12", "reads", n_reads - r0, 1);
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMN; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) begin
            mem[100 + i] = mk(20'(i * 20'h01000), 12'h200, 1, 1, 1, 0);
            mem[300 + i] = mk(20'h77000, 12'h200, 1, 1, 1, 1);
        end
        mem[105] = mk(20'hFFF00, 12'h200, 1, 1, 1, 0);
        mem[106] = mk(20'h06000, 12'h200, 0, 1, 1, 1);
        mem[107] = mk(20'h07000, 12'h080, 1, 1, 1, 1);
        mem[108] = mk(20'h08000, 12'h100, 1, 1, 0, 0);
        mem[109] = mk(20'h09000, 12'h100, 1, 0, 0, 1);
        mem[110] = mk(20'h0A000, 12'h010, 0, 0, 0, 0);
        mem[111] = mk(20'h0B000, 12'h010, 1, 0, 0, 0);
        mem[112] = mk(20'h0C000, 12'h000, 1, 1, 1, 1);
        mem[120] = mk(20'h0D000, 12'h000, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        set_cfg(10'd100, 7'd16);
        repeat (2) @(negedge clk);
        t_translate();
        t_length();
        t_invalid();
        t_limit();
        t_perm();
        t_priority();
        t_cache();
        t_invalidate();
        t_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule